// File: doc/BRIEF.md
# DRAM Controller Operational State Machine

This block holds the operational state of a DRAM protocol controller. Software puts a state-change command on a command port. A three-bit status output always shows the current state. Four states are settled: memory-init, config, access and low-power. Each move between them goes through a transient request state, and that request state shows on the status output for a fixed number of cycles, set per request kind by a parameter. A command that is not legal in the current state is dropped.

A built-in reference sequencer can drive the machine to config or to access from any state. It issues the needed commands in order and waits out every request state. From low-power it always wakes to access first and only then asks for config. While the sequencer is busy, commands from the software port are ignored.

Top module: `dram_op_ctrl`

## Requirements
- R1: The status output uses this encoding: 0 memory-init, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request, 7 low-power-exit-request. After reset the status is 0, and the sequencer's busy and done outputs are 0.
- R2: Command codes are 0 init, 1 config, 2 go, 3 sleep, 4 wakeup. A config command (1) taken in memory-init (0) or in access (3) moves to config-request (2) and then settles in config (1).
- R3: A go command (2) taken in config (1) moves to access-request (4) and then settles in access (3).
- R4: A sleep command (3) is accepted only in access (3). It moves to low-power-entry-request (6) and then settles in low-power (5).
- R5: A wakeup command (4) taken in low-power (5) moves to low-power-exit-request (7) and always settles in access (3), never in config. Low-power is left only through state 7.
- R6: A request state is shown for exactly its parameter's cycle count: CFG_REQ_CYCLES for state 2, GO_REQ_CYCLES for 4, SLEEP_REQ_CYCLES for 6 and WAKE_REQ_CYCLES for 7. The target state follows on the next edge.
- R7: The state does not change for any of these: a command that is not legal in the current state (including init), any command taken during a request state, and cmd_valid_i low.
- R8: A pulse on seq_start_i with seq_goal_i = 0 (config) or 1 (access) drives the machine to that goal from any state. From low-power the status passes 5, 7, 3, 2, 1 on the way to config. From memory-init it passes 0, 2, 1, 4, 3 on the way to access.
- R9: seq_busy_o is high from the edge after the start pulse until the goal is reached. seq_done_o then pulses for one cycle, 1 + sum(request cycles + 1) edges after the start edge. While busy, software commands and new start pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Software command strobe |
| cmd_i | input | 3 | Software command code |
| seq_start_i | input | 1 | Starts the reference sequencer |
| seq_goal_i | input | 1 | Sequencer goal: 0 config, 1 access |
| status_o | output | 3 | Current operational state |
| seq_busy_o | output | 1 | Sequencer is running |
| seq_done_o | output | 1 | One-cycle pulse when the goal is reached |

## Verification
An accepted command shows as a request state on the status one edge after it is taken. The target state shows exactly the request's cycle count of edges later. The bench samples on the falling edge and checks both the last request cycle and the first settled cycle, so a dwell that is off by one in either direction is caught. For a sequencer run, the bench counts edges from the start edge to the first sample with done high and compares the count with 1 plus the sum of (request cycles + 1) over the hops. It also logs every change of status along the way and compares that list with the expected path.

// File: rtl/dram_op_pkg.sv
package dram_op_pkg;
  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_CFG     = 3'd1,
    ST_CFG_REQ = 3'd2,
    ST_ACC     = 3'd3,
    ST_ACC_REQ = 3'd4,
    ST_LP      = 3'd5,
    ST_LP_ENT  = 3'd6,
    ST_LP_EXIT = 3'd7
  } op_state_e;

  typedef enum logic [2:0] {
    CMD_INIT  = 3'd0,
    CMD_CFG   = 3'd1,
    CMD_GO    = 3'd2,
    CMD_SLEEP = 3'd3,
    CMD_WAKE  = 3'd4
  } op_cmd_e;

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/op_dwell_timer.sv
module op_dwell_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  assign expire_o = active_q && (cnt_q == lim_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      lim_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      lim_q    <= limit_i;
    end else if (active_q) begin
      if (expire_o) active_q <= 1'b0;
      else          cnt_q    <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/op_state_core.sv
module op_state_core
  import dram_op_pkg::*;
#(
  parameter int CFG_REQ_CYCLES   = 3,
  parameter int GO_REQ_CYCLES    = 2,
  parameter int SLEEP_REQ_CYCLES = 4,
  parameter int WAKE_REQ_CYCLES  = 5
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_valid_i,
  input  logic [2:0] cmd_i,
  output op_state_e state_o
);
  localparam int MAX_CYC = max4(CFG_REQ_CYCLES, GO_REQ_CYCLES, SLEEP_REQ_CYCLES, WAKE_REQ_CYCLES);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] CFG_LIM   = CNT_W'(CFG_REQ_CYCLES);
  localparam logic [CNT_W-1:0] GO_LIM    = CNT_W'(GO_REQ_CYCLES);
  localparam logic [CNT_W-1:0] SLEEP_LIM = CNT_W'(SLEEP_REQ_CYCLES);
  localparam logic [CNT_W-1:0] WAKE_LIM  = CNT_W'(WAKE_REQ_CYCLES);

  op_state_e        st_q, st_d;
  logic             arm;
  logic [CNT_W-1:0] lim;
  logic             expire;

  op_dwell_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (arm),
    .limit_i  (lim),
    .expire_o (expire)
  );

  always_comb begin
    st_d = st_q;
    arm  = 1'b0;
    lim  = '0;
    unique case (st_q)
      ST_INIT: if (cmd_valid_i && cmd_i == CMD_CFG) begin
        st_d = ST_CFG_REQ; arm = 1'b1; lim = CFG_LIM;
      end
      ST_ACC: if (cmd_valid_i && cmd_i == CMD_CFG) begin
        st_d = ST_CFG_REQ; arm = 1'b1; lim = CFG_LIM;
      end else if (cmd_valid_i && cmd_i == CMD_SLEEP) begin
        st_d = ST_LP_ENT; arm = 1'b1; lim = SLEEP_LIM;
      end
      ST_CFG: if (cmd_valid_i && cmd_i == CMD_GO) begin
        st_d = ST_ACC_REQ; arm = 1'b1; lim = GO_LIM;
      end
      ST_LP: if (cmd_valid_i && cmd_i == CMD_WAKE) begin
        st_d = ST_LP_EXIT; arm = 1'b1; lim = WAKE_LIM;
      end
      ST_CFG_REQ: if (expire) st_d = ST_CFG;
      ST_ACC_REQ: if (expire) st_d = ST_ACC;
      ST_LP_ENT:  if (expire) st_d = ST_LP;
      ST_LP_EXIT: if (expire) st_d = ST_ACC;
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_INIT;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/op_ref_seq.sv
module op_ref_seq
  import dram_op_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      goal_access_i,
  input  op_state_e status_i,
  output logic      cmd_valid_o,
  output op_cmd_e   cmd_o,
  output logic      busy_o,
  output logic      done_o
);
  logic running_q, goal_q, done_q, at_goal;

  assign at_goal = status_i == (goal_q ? ST_ACC : ST_CFG);

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_o       = CMD_INIT;
    if (running_q && !at_goal) begin
      unique case (status_i)
        ST_INIT: begin cmd_valid_o = 1'b1; cmd_o = CMD_CFG;  end
        ST_CFG:  begin cmd_valid_o = 1'b1; cmd_o = CMD_GO;   end
        ST_ACC:  begin cmd_valid_o = 1'b1; cmd_o = CMD_CFG;  end
        ST_LP:   begin cmd_valid_o = 1'b1; cmd_o = CMD_WAKE; end
        default: cmd_valid_o = 1'b0;  // request state: wait
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      goal_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!running_q && start_i) begin
        running_q <= 1'b1;
        goal_q    <= goal_access_i;
      end else if (running_q && at_goal) begin
        running_q <= 1'b0;
        done_q    <= 1'b1;
      end
    end
  end

  assign busy_o = running_q;
  assign done_o = done_q;
endmodule

// File: rtl/dram_op_ctrl.sv
module dram_op_ctrl
  import dram_op_pkg::*;
#(
  parameter int CFG_REQ_CYCLES   = 3,
  parameter int GO_REQ_CYCLES    = 2,
  parameter int SLEEP_REQ_CYCLES = 4,
  parameter int WAKE_REQ_CYCLES  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  input  logic       seq_start_i,
  input  logic       seq_goal_i,
  output logic [2:0] status_o,
  output logic       seq_busy_o,
  output logic       seq_done_o
);
  op_state_e  state;
  logic       seq_cmd_valid;
  op_cmd_e    seq_cmd;
  logic       core_cmd_valid;
  logic [2:0] core_cmd;

  // sequencer owns the command path while busy
  assign core_cmd_valid = seq_busy_o ? seq_cmd_valid : cmd_valid_i;
  assign core_cmd       = seq_busy_o ? seq_cmd : cmd_i;

  op_state_core #(
    .CFG_REQ_CYCLES   (CFG_REQ_CYCLES),
    .GO_REQ_CYCLES    (GO_REQ_CYCLES),
    .SLEEP_REQ_CYCLES (SLEEP_REQ_CYCLES),
    .WAKE_REQ_CYCLES  (WAKE_REQ_CYCLES)
  ) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (core_cmd_valid),
    .cmd_i       (core_cmd),
    .state_o     (state)
  );

  op_ref_seq i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (seq_start_i),
    .goal_access_i (seq_goal_i),
    .status_i      (state),
    .cmd_valid_o   (seq_cmd_valid),
    .cmd_o         (seq_cmd),
    .busy_o        (seq_busy_o),
    .done_o        (seq_done_o)
  );

  assign status_o = state;
endmodule

// File: rtl/dram_op_ctrl_chk.sv
module dram_op_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_cmd_valid_i,
  input logic [2:0] core_cmd_i,
  input logic [2:0] status_i,
  input logic       busy_i,
  input logic       done_i
);
  // R2
  cfg_req_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i == 3'd2 |=> (status_i == 3'd2 || status_i == 3'd1));

  // R3
  go_from_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 3'd1 && core_cmd_valid_i && core_cmd_i == 3'd2) |=> status_i == 3'd4);

  // R4
  sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 3'd3 && core_cmd_valid_i && core_cmd_i == 3'd3) |=> status_i == 3'd6);

  // R5
  lp_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i == 3'd5 |=> (status_i == 3'd5 || status_i == 3'd7));

  // R5
  wake_to_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i == 3'd7 |=> (status_i == 3'd7 || status_i == 3'd3));

  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 3'd1 && !core_cmd_valid_i) |=> status_i == 3'd1);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);
endmodule

bind dram_op_ctrl dram_op_ctrl_chk i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .core_cmd_valid_i (core_cmd_valid),
  .core_cmd_i       (core_cmd),
  .status_i         (status_o),
  .busy_i           (seq_busy_o),
  .done_i           (seq_done_o)
);

// File: tb/test_dram_op_ctrl.sv
`timescale 1ns/1ps
module test_dram_op_ctrl;
  localparam int CC = 3, GC = 2, SC = 4, WC = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic       seq_start = 1'b0;
  logic       seq_goal = 1'b0;
  logic [2:0] status;
  logic       busy, done;

  int checks = 0;
  int errors = 0;
  int traj [16];
  int tlen;

  always #10 clk = ~clk;

  dram_op_ctrl #(
    .CFG_REQ_CYCLES(CC), .GO_REQ_CYCLES(GC), .SLEEP_REQ_CYCLES(SC), .WAKE_REQ_CYCLES(WC)
  ) i_dram_op_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .seq_start_i(seq_start), .seq_goal_i(seq_goal),
    .status_o(status), .seq_busy_o(busy), .seq_done_o(done)
  );

  // vector table: command, request state, dwell (0 = ignored), final state
  localparam int NV = 12;
  localparam int V_CMD  [NV] = '{2, 3, 1, 1, 2, 4, 3, 1, 2, 4, 1, 0};
  localparam int V_REQ  [NV] = '{0, 0, 2, 1, 4, 3, 6, 5, 5, 7, 2, 1};
  localparam int V_DW   [NV] = '{0, 0, CC, 0, GC, 0, SC, 0, 0, WC, CC, 0};
  localparam int V_FIN  [NV] = '{0, 0, 1, 1, 3, 3, 5, 5, 5, 3, 1, 1};
  localparam string V_TAG [NV] = '{"R7", "R4", "R2", "R7", "R3", "R7", "R4", "R5", "R7", "R5", "R2", "R7"};

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input int c);
    cmd_valid = 1'b1;
    cmd = 3'(c);
    tick();
    cmd_valid = 1'b0;
  endtask

  // pulse start, then count edges until done; log status changes
  task automatic run_seq(input logic goal, input int exp_edges, input string tag,
                         input logic hold_sleep);
    int n;
    tlen = 1;
    traj[0] = int'(status);
    seq_goal = goal;
    seq_start = 1'b1;
    tick();
    seq_start = 1'b0;
    if (hold_sleep) begin cmd_valid = 1'b1; cmd = 3'd3; end
    if (int'(status) != traj[tlen-1] && tlen < 16) begin traj[tlen] = int'(status); tlen++; end
    n = 0;
    while (!done && n < 200) begin
      tick();
      n++;
      if (int'(status) != traj[tlen-1] && tlen < 16) begin traj[tlen] = int'(status); tlen++; end
    end
    cmd_valid = 1'b0;
    chk(n, exp_edges, {tag, " done edge"});
    chk(int'(busy), 0, {tag, " busy after done"});
    tick();
    chk(int'(done), 0, {tag, " done one cycle"});
  endtask

  task automatic chk_traj(input int exp [16], input int len, input string tag);
    chk(tlen, len, {tag, " path length"});
    for (int k = 0; k < len && k < tlen; k++) chk(traj[k], exp[k], {tag, " path step"});
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p [16];
    @(negedge clk);
    // R1 reset values
    chk(int'(status), 0, "R1 status in reset");
    chk(int'(busy), 0, "R1 busy in reset");
    chk(int'(done), 0, "R1 done in reset");
    tick();
    rst_n = 1'b1;
    tick();
    chk(int'(status), 0, "R1 status after reset");

    for (int i = 0; i < NV; i++) begin
      issue(V_CMD[i]);
      if (V_DW[i] == 0) begin
        chk(int'(status), V_FIN[i], {V_TAG[i], " ignored"});
        tick();
        chk(int'(status), V_FIN[i], {V_TAG[i], " still ignored"});
      end else begin
        chk(int'(status), V_REQ[i], {V_TAG[i], " request entry"});
        repeat (V_DW[i] - 1) tick();
        chk(int'(status), V_REQ[i], "R6 last request cycle");
        tick();
        chk(int'(status), V_FIN[i], {V_TAG[i], " settled (R6)"});
      end
    end

    // R7 valid low with a legal code
    cmd = 3'd2;
    repeat (3) tick();
    chk(int'(status), 1, "R7 valid low");

    // R7 command during request state is dropped
    issue(2);
    chk(int'(status), 4, "R3 go request");
    issue(3);
    chk(int'(status), 4, "R7 sleep during request");
    tick();
    chk(int'(status), 3, "R7 settles in access");
    tick();
    chk(int'(status), 3, "R7 sleep not pending");

    // R9 access -> config with software sleep held while busy
    run_seq(1'b0, 1 + (CC + 1), "R9 seq to config", 1'b1);
    p = '{3, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    chk_traj(p, 3, "R9 sw ignored");
    chk(int'(status), 1, "R8 at config");

    // R8 config -> access
    run_seq(1'b1, 1 + (GC + 1), "R8 seq to access", 1'b0);
    p = '{1, 4, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    chk_traj(p, 3, "R8 cfg to acc");

    // R8 low-power -> config via access
    issue(3);
    repeat (SC) tick();
    chk(int'(status), 5, "R4 in low power");
    run_seq(1'b0, 1 + (WC + 1) + (CC + 1), "R8 seq from lp", 1'b0);
    p = '{5, 7, 3, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    chk_traj(p, 5, "R8 lp wakes first");

    // R9 goal already reached
    run_seq(1'b0, 1, "R9 at goal", 1'b0);
    chk(int'(status), 1, "R9 state unchanged");

    // R8 memory-init -> access after a fresh reset
    rst_n = 1'b0;
    tick();
    chk(int'(status), 0, "R1 status after second reset");
    rst_n = 1'b1;
    tick();
    run_seq(1'b1, 1 + (CC + 1) + (GC + 1), "R8 seq from init", 1'b0);
    p = '{0, 2, 1, 4, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    chk_traj(p, 5, "R8 init to acc");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule